// File: doc/BRIEF.md
# Three-Channel Interval Timer Register Interface

This block is the byte-wide register front end of a three-channel interval timer. A host reaches it through a 2-bit address and an 8-bit data path. Addresses 0 to 2 are the count ports of channels 0 to 2, and address 3 is a write-only control port. The block decodes control words and keeps, for each channel, the configured access mode, counting mode and BCD flag. It also orders the bytes of 16-bit transfers, holds a snapshot of the count and a snapshot of a status byte, and issues a load strobe with a 16-bit value whenever a complete count has been written.

The counters are not part of the block. Each channel presents its live 16-bit count and its output level to the interface. The interface returns this live count, or the frozen snapshot of it, to the host one byte at a time. The configuration fields are driven out so that the counters can act on them.

A control word with 3 in its channel field is a multi-channel snapshot command. It can freeze the count, the status, or both, on any subset of the channels. A snapshot survives until the host has read it, so repeating the command never overwrites one that is still pending.

Top module: `tmr_busif`

## Requirements
- R1: After reset every channel has access mode 3 (low byte then high byte), mode 0 and BCD 0, no load strobe is active and no snapshot is pending, so the first read of a count port returns the low byte of the live count.
- R2: A write to address 3 with bits 7:6 = c (0 to 2) and bits 5:4 nonzero sets channel c's access (bits 5:4: 1 low only, 2 high only, 3 low then high), mode (bits 3:1) and BCD (bit 0) on the outputs from the next cycle, and returns both byte sequencers of that channel to the low byte.
- R3: In access mode 1 a data write of byte b pulses that channel's load strobe for exactly one cycle, the cycle after the write, with load value {8'h00, b}.
- R4: In access mode 2 a data write of byte b loads {b, 8'h00}.
- R5: In access mode 3 the first data write only stores the low byte and raises no strobe. The second data write loads {high, low}.
- R6: With nothing latched, a read returns the live low byte in mode 1 and the live high byte in mode 2. In mode 3 successive reads alternate between the low byte and the high byte, starting with the low byte.
- R7: A control word with bits 5:4 = 0 freezes the count of the channel in bits 7:6 and leaves its access, mode and BCD unchanged. Reads return the frozen value in place of the live one (in mode 3 low byte then high byte), and after the last byte is read the channel returns to live reads.
- R8: While a count snapshot of a channel is not fully read, a further latch command for that channel does not change it.
- R9: A control word with bits 7:6 = 3 acts on channel 0, 1 and 2 when bit 1, 2 and 3 respectively is set. Bit 5 low freezes the count and bit 4 low freezes the status byte {output, 0, access[1:0], mode[2:0], BCD}. Channels whose select bit is clear are not affected.
- R10: A pending status byte is returned before any count byte, is cleared by that one read, and is not overwritten by further status commands while it is pending.
- R11: A read of address 3 returns 8'hFF and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address: 0 to 2 count ports, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; read side effects take place at the clock edge |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| live_count | input | 48 | Live 16-bit count of each channel, channel c at [16c+15:16c] |
| cnt_out | input | 3 | Output level of each counter |
| load_strobe | output | 3 | One-cycle pulse per channel when a full count has been written |
| load_value | output | 48 | Count value to load, channel c at [16c+15:16c] |
| mode_o | output | 9 | Mode of each channel, channel c at [3c+2:3c] |
| access_o | output | 6 | Access mode of each channel, channel c at [2c+1:2c] |
| bcd_o | output | 3 | BCD flag of each channel |

## Verification
Read data depends only on the address and the current state, so the bench samples it in the same cycle that the read strobe is high, before the edge that consumes the byte. The configuration fields, the snapshots and the load strobe all change at the edge that registers the write, so the bench checks them at the falling edge of the next cycle. It checks at the falling edge of the cycle after that that the load strobe has dropped. Live counts are changed between the latch command and the reads, so a snapshot that was not taken, or that was taken twice, shows up in the data that is returned.

// File: rtl/tmr_busif_pkg.sv
package tmr_busif_pkg;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_LO   = 2'd1,
      ACC_HI   = 2'd2,
      ACC_WORD = 2'd3
   } acc_e;

   typedef struct packed {
      logic [2:0] mode;
      acc_e       acc;
      logic       bcd;
   } chcfg_t;

   localparam logic [1:0] CTL_ADDR = 2'd3;
   localparam logic [1:0] SEL_RB   = 2'd3;

   function automatic logic [7:0] mk_status(input logic lvl, input chcfg_t c);
      return {lvl, 1'b0, c.acc, c.mode, c.bcd};
   endfunction

endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
   import tmr_busif_pkg::*;
#(
   parameter int NUM_CH = 3
) (
   input  logic              wr,
   input  logic [1:0]        addr,
   input  logic [7:1]        ctl,
   output logic [NUM_CH-1:0] cfg_we,
   output logic [NUM_CH-1:0] cnt_lat,
   output logic [NUM_CH-1:0] sts_lat,
   output logic [NUM_CH-1:0] data_we
);

   logic ctl_hit, rb_cmd, acc_zero;

   assign ctl_hit  = wr && (addr == CTL_ADDR);
   assign rb_cmd   = ctl_hit && (ctl[7:6] == SEL_RB);
   assign acc_zero = (ctl[5:4] == 2'd0);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
      logic sel_me, rb_me;
      assign sel_me      = ctl_hit && (ctl[7:6] == 2'(ch));
      assign rb_me       = rb_cmd && ctl[ch+1];
      assign cfg_we[ch]  = sel_me && !acc_zero;
      assign cnt_lat[ch] = (sel_me && acc_zero) || (rb_me && !ctl[5]);
      assign sts_lat[ch] = rb_me && !ctl[4];
      assign data_we[ch] = wr && (addr == 2'(ch));
   end

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
   import tmr_busif_pkg::*;
#(
   parameter int         DATA_W  = 8,
   parameter logic [1:0] RST_ACC = 2'd3,
   localparam int        CNT_W   = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  chcfg_t            cfg_in,
   input  logic              data_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_hit,
   input  logic              cnt_lat,
   input  logic              sts_lat,
   input  logic [CNT_W-1:0]  live,
   input  logic              lvl,
   output chcfg_t            cfg,
   output logic              load_stb,
   output logic [CNT_W-1:0]  load_val,
   output logic [DATA_W-1:0] rdata
);

   logic              wseq, rseq;
   logic [DATA_W-1:0] wlo;
   acc_e              cl_st;
   logic [CNT_W-1:0]  lat_q;
   logic              st_vld;
   logic [7:0]        st_q;

   // configuration and write byte sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg      <= '{mode: 3'd0, acc: acc_e'(RST_ACC), bcd: 1'b0};
         wseq     <= 1'b0;
         wlo      <= '0;
         load_stb <= 1'b0;
         load_val <= '0;
      end else begin
         load_stb <= 1'b0;
         if (cfg_we) begin
            cfg  <= cfg_in;
            wseq <= 1'b0;
         end else if (data_we) begin
            unique case (cfg.acc)
               ACC_HI: begin
                  load_stb <= 1'b1;
                  load_val <= {wdata, {DATA_W{1'b0}}};
               end
               ACC_WORD: begin
                  if (!wseq) begin
                     wlo  <= wdata;
                     wseq <= 1'b1;
                  end else begin
                     load_stb <= 1'b1;
                     load_val <= {wdata, wlo};
                     wseq     <= 1'b0;
                  end
               end
               default: begin
                  load_stb <= 1'b1;
                  load_val <= {{DATA_W{1'b0}}, wdata};
               end
            endcase
         end
      end
   end

   // snapshots and read byte sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rseq   <= 1'b0;
         cl_st  <= ACC_NONE;
         lat_q  <= '0;
         st_vld <= 1'b0;
         st_q   <= '0;
      end else begin
         if (cfg_we) rseq <= 1'b0;
         if (cnt_lat && cl_st == ACC_NONE) begin
            lat_q <= live;
            cl_st <= cfg.acc;
         end
         if (sts_lat && !st_vld) begin
            st_q   <= mk_status(lvl, cfg);
            st_vld <= 1'b1;
         end
         if (rd_hit) begin
            if (st_vld) begin
               st_vld <= 1'b0;
            end else if (cl_st != ACC_NONE) begin
               cl_st <= (cl_st == ACC_WORD) ? ACC_HI : ACC_NONE;
            end else if (cfg.acc == ACC_WORD) begin
               rseq <= !rseq;
            end
         end
      end
   end

   always_comb begin
      if (st_vld) begin
         rdata = st_q;
      end else if (cl_st != ACC_NONE) begin
         rdata = (cl_st == ACC_HI) ? lat_q[CNT_W-1:DATA_W] : lat_q[DATA_W-1:0];
      end else begin
         unique case (cfg.acc)
            ACC_HI:   rdata = live[CNT_W-1:DATA_W];
            ACC_WORD: rdata = rseq ? live[CNT_W-1:DATA_W] : live[DATA_W-1:0];
            default:  rdata = live[DATA_W-1:0];
         endcase
      end
   end

   // R10: a pending status byte stays untouched until it is read
   a_r10_status_held: assert property (@(posedge clk) disable iff (!rst_n)
      st_vld && !rd_hit |=> st_vld && $stable(st_q));

   // R8: a pending count snapshot is not re-taken
   a_r8_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_st != ACC_NONE) && !rd_hit |=> $stable(lat_q));

   // R3: a load strobe only follows a data write
   a_r3_strobe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |-> $past(data_we));

   // R5: first byte of a word write raises no strobe
   a_r5_word_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      data_we && !cfg_we && (cfg.acc == ACC_WORD) && !wseq |=> !load_stb);

   // R7: a count latch leaves the configuration alone
   a_r7_latch_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_lat && !cfg_we |=> $stable(cfg));

endmodule

// File: rtl/tmr_busif.sv
module tmr_busif
   import tmr_busif_pkg::*;
#(
   parameter int         NUM_CH  = 3,
   parameter int         DATA_W  = 8,
   parameter logic [1:0] RST_ACC = 2'd3,
   localparam int        CNT_W   = 2 * DATA_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   input  logic                    bus_wr,
   input  logic                    bus_rd,
   output logic [DATA_W-1:0]       bus_rdata,
   input  logic [NUM_CH*CNT_W-1:0] live_count,
   input  logic [NUM_CH-1:0]       cnt_out,
   output logic [NUM_CH-1:0]       load_strobe,
   output logic [NUM_CH*CNT_W-1:0] load_value,
   output logic [NUM_CH*3-1:0]     mode_o,
   output logic [NUM_CH*2-1:0]     access_o,
   output logic [NUM_CH-1:0]       bcd_o
);

   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
      $error("tmr_busif: NUM_CH must be 1 to 3");
   end
   if (DATA_W != 8) begin : g_bad_dw
      $error("tmr_busif: DATA_W must be 8");
   end
   if (RST_ACC == 2'd0) begin : g_bad_acc
      $error("tmr_busif: RST_ACC must be a data access mode");
   end

   logic [NUM_CH-1:0] cfg_we, cnt_lat, sts_lat, data_we;
   chcfg_t            cfg_in;
   chcfg_t            cfg    [NUM_CH];
   logic [DATA_W-1:0] ch_rd  [NUM_CH];

   assign cfg_in = '{mode: bus_wdata[3:1], acc: acc_e'(bus_wdata[5:4]), bcd: bus_wdata[0]};

   tmr_ctl_decode #(.NUM_CH(NUM_CH)) u_dec (
      .wr      (bus_wr),
      .addr    (bus_addr),
      .ctl     (bus_wdata[7:1]),
      .cfg_we  (cfg_we),
      .cnt_lat (cnt_lat),
      .sts_lat (sts_lat),
      .data_we (data_we)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic rd_hit;
      assign rd_hit = bus_rd && (bus_addr == 2'(ch));

      tmr_chan_regs #(.DATA_W(DATA_W), .RST_ACC(RST_ACC)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (cfg_we[ch]),
         .cfg_in   (cfg_in),
         .data_we  (data_we[ch]),
         .wdata    (bus_wdata),
         .rd_hit   (rd_hit),
         .cnt_lat  (cnt_lat[ch]),
         .sts_lat  (sts_lat[ch]),
         .live     (live_count[ch*CNT_W +: CNT_W]),
         .lvl      (cnt_out[ch]),
         .cfg      (cfg[ch]),
         .load_stb (load_strobe[ch]),
         .load_val (load_value[ch*CNT_W +: CNT_W]),
         .rdata    (ch_rd[ch])
      );

      assign mode_o[ch*3 +: 3]   = cfg[ch].mode;
      assign access_o[ch*2 +: 2] = cfg[ch].acc;
      assign bcd_o[ch]           = cfg[ch].bcd;
   end

   always_comb begin
      bus_rdata = {DATA_W{1'b1}};
      for (int ch = 0; ch < NUM_CH; ch++) begin
         if (bus_addr == 2'(ch)) bus_rdata = ch_rd[ch];
      end
   end

   // R11: the control address reads as all ones
   a_r11_ctl_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && (bus_addr == CTL_ADDR) |-> bus_rdata == {DATA_W{1'b1}});

   // R3: one write per cycle gives at most one load strobe
   a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load_strobe));

   a_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));

endmodule

// File: tb/sim_tmr_busif.sv
module sim_tmr_busif;

   localparam int CLK_T = 10;
   localparam int NV    = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_rdata;
   logic [47:0] live_count = {16'h0F0E, 16'hABCD, 16'h1234};
   logic [2:0]  cnt_out = 3'b101;
   logic [2:0]  load_strobe;
   logic [47:0] load_value;
   logic [8:0]  mode_o;
   logic [5:0]  access_o;
   logic [2:0]  bcd_o;

   int checks = 0, fails = 0, cyc = 0;
   bit done = 1'b0;

   always #(CLK_T/2) clk = ~clk;

   tmr_busif u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .live_count(live_count), .cnt_out(cnt_out), .load_strobe(load_strobe),
      .load_value(load_value), .mode_o(mode_o), .access_o(access_o), .bcd_o(bcd_o)
   );

   // vector: {is_read, addr, wdata, expected, requirement number}
   localparam logic [22:0] VEC [NV] = '{
      {1'b1, 2'd0, 8'h00, 8'h34, 4'd1},  // R1 reset: low byte first
      {1'b1, 2'd3, 8'h00, 8'hFF, 4'd11}, // R11
      {1'b1, 2'd0, 8'h00, 8'h12, 4'd6},  // R6 word alternates
      {1'b1, 2'd0, 8'h00, 8'h34, 4'd6},
      {1'b0, 2'd3, 8'h10, 8'h00, 4'd2},  // R2 ch0 low only
      {1'b1, 2'd0, 8'h00, 8'h34, 4'd6},
      {1'b1, 2'd0, 8'h00, 8'h34, 4'd6},
      {1'b0, 2'd3, 8'h26, 8'h00, 4'd2},  // ch0 high only, mode 3
      {1'b1, 2'd0, 8'h00, 8'h12, 4'd6},
      {1'b1, 2'd0, 8'h00, 8'h12, 4'd6},
      {1'b0, 2'd3, 8'h74, 8'h00, 4'd2},  // ch1 word, mode 2
      {1'b1, 2'd1, 8'h00, 8'hCD, 4'd6},
      {1'b1, 2'd3, 8'h00, 8'hFF, 4'd11},
      {1'b1, 2'd1, 8'h00, 8'hAB, 4'd6},
      {1'b1, 2'd1, 8'h00, 8'hCD, 4'd6},
      {1'b0, 2'd3, 8'h74, 8'h00, 4'd2},  // R2 sequencer back to low
      {1'b1, 2'd1, 8'h00, 8'hCD, 4'd2},
      {1'b1, 2'd1, 8'h00, 8'hAB, 4'd6},
      {1'b1, 2'd2, 8'h00, 8'h0E, 4'd1},  // ch2 reset word mode
      {1'b1, 2'd2, 8'h00, 8'h0F, 4'd1}
   };

   task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input int req);
      bus_addr = a; bus_rd = 1'b1;
      #(CLK_T/4);
      chk(req, {8'h00, bus_rdata}, {8'h00, exp});
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 100000 && !done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state of the outputs
      chk(1, {10'd0, access_o}, 16'h003F);
      chk(1, {7'd0, mode_o}, 16'h0000);
      chk(1, {13'd0, bcd_o}, 16'h0000);
      chk(1, {13'd0, load_strobe}, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][22]) rd(VEC[i][21:20], VEC[i][11:4], int'(VEC[i][3:0]));
         else            wr(VEC[i][21:20], VEC[i][19:12]);
      end

      // R2 field outputs, other channel untouched
      wr(2'd3, 8'hB7);
      chk(2, {14'd0, access_o[5:4]}, 16'd3);
      chk(2, {13'd0, mode_o[8:6]}, 16'd3);
      chk(2, {15'd0, bcd_o[2]}, 16'd1);
      chk(2, {13'd0, mode_o[2:0]}, 16'd3);
      chk(2, {14'd0, access_o[1:0]}, 16'd2);

      // R3 low-only load
      wr(2'd3, 8'h90);
      wr(2'd2, 8'h5A);
      chk(3, {13'd0, load_strobe}, 16'h0004);
      chk(3, load_value[47:32], 16'h005A);
      @(negedge clk);
      chk(3, {13'd0, load_strobe}, 16'h0000);

      // R4 high-only load
      wr(2'd3, 8'hA0);
      wr(2'd2, 8'h5A);
      chk(4, {13'd0, load_strobe}, 16'h0004);
      chk(4, load_value[47:32], 16'h5A00);
      wr(2'd0, 8'h77);
      chk(4, load_value[15:0], 16'h7700);

      // R5 word load
      wr(2'd3, 8'hB0);
      wr(2'd2, 8'h11);
      chk(5, {13'd0, load_strobe}, 16'h0000);
      wr(2'd2, 8'h22);
      chk(5, {13'd0, load_strobe}, 16'h0004);
      chk(5, load_value[47:32], 16'h2211);

      // R7 counter latch on ch1
      wr(2'd3, 8'h40);
      live_count[31:16] = 16'h5555;
      chk(7, {14'd0, access_o[3:2]}, 16'd3);
      chk(7, {13'd0, mode_o[5:3]}, 16'd2);
      rd(2'd1, 8'hCD, 7);
      rd(2'd1, 8'hAB, 7);
      rd(2'd1, 8'h55, 7);
      rd(2'd1, 8'h55, 7);

      // R8 no re-latch while pending
      wr(2'd3, 8'h40);
      live_count[31:16] = 16'h7777;
      wr(2'd3, 8'h40);
      rd(2'd1, 8'h55, 8);
      rd(2'd1, 8'h55, 8);
      rd(2'd1, 8'h77, 8);
      wr(2'd3, 8'h40);
      rd(2'd1, 8'h77, 8);
      live_count[31:16] = 16'h9A98;
      wr(2'd3, 8'h40);
      rd(2'd1, 8'h77, 8);
      rd(2'd1, 8'h9A, 8);

      // R10 status precedence, single read, no overwrite
      wr(2'd3, 8'h3B);
      wr(2'd3, 8'hE2);
      rd(2'd0, 8'hBB, 10);
      rd(2'd0, 8'h34, 10);
      wr(2'd3, 8'hE2);
      cnt_out[0] = 1'b0;
      wr(2'd3, 8'hE2);
      rd(2'd0, 8'hBB, 10);
      rd(2'd0, 8'h12, 10);
      cnt_out[0] = 1'b1;

      // R9 read-back of all three channels
      wr(2'd3, 8'hCE);
      live_count = '0;
      rd(2'd2, 8'hB0, 9);
      rd(2'd2, 8'h0E, 9);
      rd(2'd2, 8'h0F, 9);
      rd(2'd2, 8'h00, 9);
      rd(2'd1, 8'h34, 9);
      rd(2'd1, 8'h98, 9);
      rd(2'd1, 8'h9A, 9);
      rd(2'd0, 8'hBB, 9);
      rd(2'd0, 8'h34, 9);
      rd(2'd0, 8'h12, 9);

      // R9 select only ch1, count only
      live_count[15:0]  = 16'h5678;
      live_count[31:16] = 16'h4321;
      wr(2'd3, 8'hD4);
      live_count[31:16] = 16'h0000;
      rd(2'd1, 8'h21, 9);
      rd(2'd1, 8'h43, 9);
      rd(2'd0, 8'h78, 9);

      // R11 control read leaves a pending latch alone
      wr(2'd3, 8'h00);
      live_count[15:0] = 16'h0000;
      chk(7, {14'd0, access_o[1:0]}, 16'd3);
      rd(2'd3, 8'hFF, 11);
      rd(2'd0, 8'h78, 11);
      rd(2'd0, 8'h56, 11);

      finish_run();
   end

endmodule